// File: doc/BRIEF.md
# PCI Master Read Command Selector

This block chooses the bus read command that a PCI bus master uses for each read request. The master supplies the start address (both 32-bit halves), the byte count, the kind of request, the cache line size, a burst cap code and three enable bits. One clock later the block returns the memory read command, the command for the first address phase, a dual-address-cycle flag and the burst length in Dwords.

The choice favours whole-line traffic. When the transfer spans a cache line boundary and holds at least one full line, a multi-line burst is chosen. When it stays inside one line but covers more than one Dword, a single-line read is chosen. Everything else, including all non-prefetchable opcode fetches, falls back to the plain memory read. A nonzero upper address half adds a dual address cycle in front of the command.

Top module: `rd_cmd_select`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises when no request was sampled, `outValid` is 0, `dualAddr` is 0, `addrCmd` is 0110 and `burstDw` is 0.
- R2: `outValid` is 1 in exactly the cycles that follow a clock edge at which `reqValid` was 1. All result outputs belong to the request sampled at that edge.
- R3: The cache line size `lineSizeDw` (in Dwords) is usable only if it is 2, 4, 8, 16, 32, 64 or 128 and not larger than the cap 2^(burstCode+1) Dwords. burstCode 0 to 7 gives a cap of 2 to 256 Dwords. With any other line size, neither 1110 nor 1100 is issued.
- R4: The Read Line command 1110 needs `cacheModeEn`, `lineSizeEn` and `readLineEn` all set. The Read Multiple command 1100 needs `cacheModeEn` and `lineSizeEn`, and does not depend on `readLineEn`.
- R5: Read Line 1110 is issued when the first byte and the last byte lie in different Dwords but in the same cache line. `burstDw` is then the number of Dwords the byte range touches.
- R6: Read Multiple 1100 is issued when the byte range crosses a cache line boundary and floor(byteCount/4) is at least one line. `burstDw` is the largest multiple of the line size that is not larger than floor(byteCount/4), limited to the cap. This case takes priority over R5.
- R7: A non-prefetchable opcode fetch (`reqKind` = 2) always gets Memory Read 0110. `reqKind` 0 is a data read and 1 is a prefetchable opcode fetch. Value 3 is treated as a data read.
- R8: `dualAddr` is 1 when `addrHi` is nonzero. `addrCmd` is then 1101 (dual address cycle); otherwise `addrCmd` equals `cmdCode`.
- R9: When neither R5 nor R6 applies, `cmdCode` is 0110 and `burstDw` is the number of Dwords the byte range touches. A byte count of 0 gives 0110 with `burstDw` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqKind | input | 2 | 0 data read, 1 prefetchable fetch, 2 non-prefetchable fetch |
| addrLo | input | 32 | Start byte address, lower half |
| addrHi | input | 32 | Start byte address, upper half |
| byteCount | input | CNTW | Transfer length in bytes |
| lineSizeDw | input | 8 | Cache line size in Dwords |
| burstCode | input | 3 | Burst cap code, cap = 2^(n+1) Dwords |
| cacheModeEn | input | 1 | Cache mode enable |
| lineSizeEn | input | 1 | Cache line size enable |
| readLineEn | input | 1 | Read Line enable |
| outValid | output | 1 | Result valid |
| cmdCode | output | 4 | Memory read command |
| addrCmd | output | 4 | Command for the first address phase |
| dualAddr | output | 1 | Dual address cycle needed |
| burstDw | output | CNTW | Burst length in Dwords |

## Verification
Every result is registered once, so it appears at the first rising edge after the request is sampled. The bench changes the inputs on the falling edge. It reads the outputs for that request on the next falling edge, in the same step before it applies the next request, so it can issue one request per cycle. Near-exhaustive sweeps cover line sizes, cap codes, enable patterns, request kinds, address offsets and byte counts. The bench also checks an idle cycle and the reset state.

// File: rtl/rdsel_pkg.sv
package rdsel_pkg;

  localparam int LINEW = 8;

  typedef enum logic [3:0] {
    CMD_MEM_READ  = 4'b0110,
    CMD_READ_LINE = 4'b1110,
    CMD_READ_MULT = 4'b1100,
    CMD_DUAL_ADDR = 4'b1101
  } pciCmdE;

  typedef enum logic [1:0] {
    KIND_DATA     = 2'd0,
    KIND_FETCH_PF = 2'd1,
    KIND_FETCH_NP = 2'd2,
    KIND_OTHER    = 2'd3
  } reqKindE;

  typedef struct packed {
    logic legal;
    logic crossDw;
    logic crossLine;
    logic fullLine;
    logic zeroCount;
  } dpFlagsT;

  typedef struct packed {
    logic load;
    logic pickMult;
    logic pickLine;
  } ctlStrobesT;

endpackage

// File: rtl/rd_cmd_datapath.sv
module rd_cmd_datapath
  import rdsel_pkg::*;
#(
  parameter int CNTW = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [31:0]      addrLo,
  input  logic [31:0]      addrHi,
  input  logic [CNTW-1:0]  byteCount,
  input  logic [LINEW-1:0] lineSizeDw,
  input  logic [2:0]       burstCode,
  input  ctlStrobesT       stb,
  output dpFlagsT          flags,
  output logic [3:0]       cmdCode,
  output logic [3:0]       addrCmd,
  output logic             dualAddr,
  output logic [CNTW-1:0]  burstDw
);

  localparam int AW   = 33;
  localparam int DWAW = AW - 2;
  localparam int CAPW = 9;

  logic [AW-1:0]   startA;
  logic [AW-1:0]   endA;
  logic [AW-1:0]   lineMask;
  logic [AW-1:0]   lineBytes;
  logic [DWAW-1:0] spanFull;
  logic [CNTW-1:0] spanDw;
  logic [CAPW-1:0] capDw;
  logic [CNTW-1:0] capExt;
  logic [CNTW-1:0] lineExt;
  logic [CNTW-1:0] wholeDw;
  logic [CNTW-1:0] lineFloor;
  logic [CNTW-1:0] multBurst;
  logic            sizeIsPow2;

  // byte range of the transfer, one extra bit so the last byte never wraps
  always_comb begin
    startA    = {1'b0, addrLo};
    endA      = startA + AW'(byteCount) - AW'(1);
    lineBytes = AW'({lineSizeDw, 2'b00});
    lineMask  = ~(lineBytes - AW'(1));
    spanFull  = endA[AW-1:2] - startA[AW-1:2] + DWAW'(1);
    spanDw    = spanFull[CNTW-1:0];
  end

  // burst cap and cache line legality
  always_comb begin
    capDw      = CAPW'(2) << burstCode;
    capExt     = CNTW'(capDw);
    lineExt    = CNTW'(lineSizeDw);
    sizeIsPow2 = $onehot(lineSizeDw) && !lineSizeDw[0];
    wholeDw    = byteCount >> 2;
    lineFloor  = wholeDw & ~(lineExt - CNTW'(1));
    multBurst  = (lineFloor > capExt) ? capExt : lineFloor;
  end

  always_comb begin
    flags.legal     = sizeIsPow2 && (CAPW'(lineSizeDw) <= capDw);
    flags.crossDw   = startA[AW-1:2] != endA[AW-1:2];
    flags.crossLine = |((startA ^ endA) & lineMask);
    flags.fullLine  = wholeDw >= lineExt;
    flags.zeroCount = byteCount == '0;
  end

  pciCmdE          cmdReg;
  logic            dualReg;
  logic [CNTW-1:0] burstReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg   <= CMD_MEM_READ;
      dualReg  <= 1'b0;
      burstReg <= '0;
    end else if (stb.load) begin
      dualReg <= |addrHi;
      if (stb.pickMult) begin
        cmdReg   <= CMD_READ_MULT;
        burstReg <= multBurst;
      end else if (stb.pickLine) begin
        cmdReg   <= CMD_READ_LINE;
        burstReg <= spanDw;
      end else begin
        cmdReg   <= CMD_MEM_READ;
        burstReg <= flags.zeroCount ? '0 : spanDw;
      end
    end
  end

  assign cmdCode  = cmdReg;
  assign dualAddr = dualReg;
  assign burstDw  = burstReg;
  assign addrCmd  = dualReg ? CMD_DUAL_ADDR : cmdReg;

  // R6: a multi-line burst is nonzero, a whole number of lines and within the cap
  p_mult_cap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && stb.pickMult) |=>
      (burstReg != '0) && (burstReg <= CNTW'(CAPW'(2) << $past(burstCode))) &&
      ((burstReg & (CNTW'($past(lineSizeDw)) - CNTW'(1))) == '0));

  // R8: the first address phase carries the dual address command exactly for high addresses
  p_dac_phase_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> ((addrCmd == CMD_DUAL_ADDR) == ($past(addrHi) != 32'd0)));

  // R5: a single-line read never covers more Dwords than one line
  p_line_fits_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && stb.pickLine) |=> (burstReg <= CNTW'($past(lineSizeDw))));

endmodule

// File: rtl/rd_cmd_control.sv
module rd_cmd_control
  import rdsel_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  input  logic       cacheModeEn,
  input  logic       lineSizeEn,
  input  logic       readLineEn,
  input  logic [LINEW-1:0] lineSizeDw,
  input  dpFlagsT    flags,
  output ctlStrobesT stb,
  output logic       outValid
);

  logic cacheUsable;
  logic fetchNoPf;

  always_comb begin
    fetchNoPf   = reqKind == KIND_FETCH_NP;
    cacheUsable = cacheModeEn && lineSizeEn && flags.legal &&
                  !flags.zeroCount && !fetchNoPf;
    stb.load     = reqValid;
    stb.pickMult = reqValid && cacheUsable && flags.crossLine && flags.fullLine;
    stb.pickLine = reqValid && cacheUsable && readLineEn &&
                   flags.crossDw && !flags.crossLine;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= reqValid;
  end

  // R2: the result strobe follows the request by one cycle
  p_valid_next_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> outValid);
  p_idle_next_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !outValid);

  // R7: non-prefetchable opcode fetches never get a cache command
  p_nonpf_plain_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == 2'd2) |-> !(stb.pickMult || stb.pickLine));

  // R4: Read Line requires all three enables
  p_line_gated_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.pickLine |-> (cacheModeEn && lineSizeEn && readLineEn));

  // R3: cache commands only with a power-of-two line of 2 to 128 Dwords
  p_legal_size_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pickMult || stb.pickLine) |-> ($onehot(lineSizeDw) && lineSizeDw != 8'd1));

endmodule

// File: rtl/rd_cmd_select.sv
module rd_cmd_select
  import rdsel_pkg::*;
#(
  parameter int CNTW = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqKind,
  input  logic [31:0]      addrLo,
  input  logic [31:0]      addrHi,
  input  logic [CNTW-1:0]  byteCount,
  input  logic [7:0]       lineSizeDw,
  input  logic [2:0]       burstCode,
  input  logic             cacheModeEn,
  input  logic             lineSizeEn,
  input  logic             readLineEn,
  output logic             outValid,
  output logic [3:0]       cmdCode,
  output logic [3:0]       addrCmd,
  output logic             dualAddr,
  output logic [CNTW-1:0]  burstDw
);

  dpFlagsT    flags;
  ctlStrobesT stb;

  rd_cmd_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqKind    (reqKind),
    .cacheModeEn(cacheModeEn),
    .lineSizeEn (lineSizeEn),
    .readLineEn (readLineEn),
    .lineSizeDw (lineSizeDw),
    .flags      (flags),
    .stb        (stb),
    .outValid   (outValid)
  );

  rd_cmd_datapath #(.CNTW(CNTW)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .addrLo    (addrLo),
    .addrHi    (addrHi),
    .byteCount (byteCount),
    .lineSizeDw(lineSizeDw),
    .burstCode (burstCode),
    .stb       (stb),
    .flags     (flags),
    .cmdCode   (cmdCode),
    .addrCmd   (addrCmd),
    .dualAddr  (dualAddr),
    .burstDw   (burstDw)
  );

endmodule

// File: tb/rd_cmd_select_bench.sv
module rd_cmd_select_bench;

  localparam int CNTW = 12;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            reqValid = 1'b0;
  logic [1:0]      reqKind = 2'd0;
  logic [31:0]     addrLo = '0;
  logic [31:0]     addrHi = '0;
  logic [CNTW-1:0] byteCount = '0;
  logic [7:0]      lineSizeDw = 8'd8;
  logic [2:0]      burstCode = 3'd3;
  logic            cacheModeEn = 1'b0;
  logic            lineSizeEn = 1'b0;
  logic            readLineEn = 1'b0;
  logic            outValid;
  logic [3:0]      cmdCode;
  logic [3:0]      addrCmd;
  logic            dualAddr;
  logic [CNTW-1:0] burstDw;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  rd_cmd_select #(.CNTW(CNTW)) u_rd_cmd_select (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .addrLo(addrLo), .addrHi(addrHi), .byteCount(byteCount),
    .lineSizeDw(lineSizeDw), .burstCode(burstCode),
    .cacheModeEn(cacheModeEn), .lineSizeEn(lineSizeEn), .readLineEn(readLineEn),
    .outValid(outValid), .cmdCode(cmdCode), .addrCmd(addrCmd),
    .dualAddr(dualAddr), .burstDw(burstDw)
  );

  always #10 clk = ~clk;

  logic [3:0]      expCmd;
  logic [3:0]      expAddrCmd;
  logic            expDual;
  logic [CNTW-1:0] expBurst;
  string           expTag;

  task automatic model();
    longint s, e, lb, cap, dw, span, fl;
    bit legal, usable, crossLine, crossDw;
    s   = longint'(addrLo);
    e   = s + longint'(byteCount) - 1;
    cap = longint'(2) << burstCode;
    dw  = longint'(byteCount) / 4;
    legal = 1'b0;
    for (int k = 1; k <= 7; k++) if (lineSizeDw == (8'd1 << k)) legal = 1'b1;
    legal = legal && (longint'(lineSizeDw) <= cap);
    lb = longint'(lineSizeDw) * 4;
    crossLine = legal && byteCount != 0 && (s / lb) != (e / lb);
    crossDw   = byteCount != 0 && (s / 4) != (e / 4);
    span      = (byteCount == 0) ? 0 : (e / 4) - (s / 4) + 1;
    usable = cacheModeEn && lineSizeEn && legal && byteCount != 0 && reqKind != 2'd2;
    expDual = addrHi != 0;
    if (usable && crossLine && dw >= longint'(lineSizeDw)) begin
      fl = (dw / longint'(lineSizeDw)) * longint'(lineSizeDw);
      if (fl > cap) fl = cap;
      expCmd = 4'b1100; expBurst = CNTW'(fl); expTag = "R6";
    end else if (usable && readLineEn && crossDw && !crossLine) begin
      expCmd = 4'b1110; expBurst = CNTW'(span); expTag = "R5";
    end else begin
      expCmd = 4'b0110; expBurst = CNTW'(span);
      if (reqKind == 2'd2) expTag = "R7";
      else if (!legal) expTag = "R3";
      else if (!(cacheModeEn && lineSizeEn && readLineEn)) expTag = "R4";
      else expTag = "R9";
    end
    expAddrCmd = expDual ? 4'b1101 : expCmd;
  endtask

  task automatic checkResult();
    total++;
    if (outValid !== 1'b1 || cmdCode !== expCmd || addrCmd !== expAddrCmd ||
        dualAddr !== expDual || burstDw !== expBurst) begin
      bad++;
      $display("FAIL %s R8 R2: got v=%0b cmd=%b acmd=%b dual=%0b burst=%0d exp v=1 cmd=%b acmd=%b dual=%0b burst=%0d (addr=%0d cnt=%0d line=%0d code=%0d kind=%0d en=%b%b%b)",
               expTag, outValid, cmdCode, addrCmd, dualAddr, burstDw,
               expCmd, expAddrCmd, expDual, expBurst, addrLo, byteCount,
               lineSizeDw, burstCode, reqKind, cacheModeEn, lineSizeEn, readLineEn);
    end
  endtask

  task automatic request(input logic [31:0] a, input logic [CNTW-1:0] c,
                         input logic [7:0] ls, input logic [2:0] bc,
                         input logic [1:0] kd, input logic [2:0] en,
                         input logic [31:0] hi);
    addrLo = a; byteCount = c; lineSizeDw = ls; burstCode = bc; reqKind = kd;
    {cacheModeEn, lineSizeEn, readLineEn} = en; addrHi = hi; reqValid = 1'b1;
    model();
    @(negedge clk);
    checkResult();
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got hung exp done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lines[7] = '{2, 4, 8, 16, 128, 3, 0};
    int offs[9]  = '{0, 1, 3, 4, 6, 60, 62, 125, 500};
    int cnts[15] = '{0, 1, 2, 3, 4, 5, 8, 9, 63, 64, 65, 200, 512, 1023, 4095};
    logic [2:0] ens[4] = '{3'b111, 3'b011, 3'b101, 3'b110};
    int n = 0;

    repeat (3) @(negedge clk);
    reqValid = 1'b1;
    @(negedge clk);
    total++;
    if (outValid !== 1'b0 || dualAddr !== 1'b0 || addrCmd !== 4'b0110 || burstDw !== '0) begin
      bad++;
      $display("FAIL R1: got v=%0b dual=%0b acmd=%b burst=%0d exp 0 0 0110 0",
               outValid, dualAddr, addrCmd, burstDw);
    end
    reqValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    total++;
    if (outValid !== 1'b0) begin
      bad++;
      $display("FAIL R1: got v=%0b exp 0 after reset release", outValid);
    end

    // R5 directed: 8 bytes inside a 16-Dword line
    request(32'd4, 12'd8, 8'd16, 3'd4, 2'd0, 3'b111, 32'd0);
    // R6 directed: 256 bytes from 0, line 8, cap 16
    request(32'd0, 12'd256, 8'd8, 3'd3, 2'd0, 3'b110, 32'd0);
    // R3 directed: line 32 above cap 16
    request(32'd4, 12'd8, 8'd32, 3'd3, 2'd0, 3'b111, 32'd0);
    // R8 directed
    request(32'd4, 12'd8, 8'd16, 3'd4, 2'd1, 3'b111, 32'h8000_0000);

    // R2: idle cycle gives no result
    reqValid = 1'b0;
    @(negedge clk);
    total++;
    if (outValid !== 1'b0) begin
      bad++;
      $display("FAIL R2: got v=%0b exp 0 after idle cycle", outValid);
    end

    for (int li = 0; li < 7; li++)
      for (int bc = 0; bc < 8; bc++)
        for (int ei = 0; ei < 4; ei++)
          for (int kd = 0; kd < 3; kd++)
            for (int oi = 0; oi < 9; oi++)
              for (int ci = 0; ci < 15; ci++) begin
                n++;
                request(32'(offs[oi]), CNTW'(cnts[ci]), 8'(lines[li]), 3'(bc),
                        2'(kd), ens[ei], (n % 7 == 3) ? (32'd1 << (n % 32)) : 32'd0);
              end

    reqValid = 1'b0;
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule